// File: doc/BRIEF.md
# Keyboard Scancode Translator and Command Responder

This block sits on the keyboard side of a serial keyboard port. Host-style scancodes arrive one per strobe. The block remembers an extended-prefix marker and filters the press and release codes of the two locking keys so that each of them behaves as a toggle. Every code that survives is mapped through a 128-entry lookup table indexed by its low seven bits. The release bit is carried over unchanged, and the resulting byte goes into a 256-byte receive queue.

Command bytes sent to the keyboard are decoded as well. Identify and layout queries clear the queue and load a fixed reply. A set-indicator command causes the byte after it to be swallowed. A small sequencer writes the reply one byte per clock. Incoming scancodes take the write port first, so the sequencer simply waits a cycle when they collide. The two lookup tables come from parameters.

Top module: `kbd_xlate_top`

## Requirements
- R1: After reset the queue is empty: `rx_avail` is 0 and `rx_data` is 0x00.
- R2: A scancode other than 0xE0 and other than a dropped lock code queues one byte. Its bit 7 equals the input bit 7, and its low 7 bits are `code[6:0] ^ NRM_XOR` (default 0x2A). Bytes leave the queue in arrival order.
- R3: Scancode 0xE0 queues nothing and arms an extended marker. The next code that is queued is mapped as `code[6:0] ^ EXT_XOR` (default 0x55) with its release bit kept, and that write clears the marker.
- R4: Caps lock (press 0x3A, release 0xBA) and num lock (press 0x45, release 0xC5) each keep a 2-bit state that starts at 0. A press flips bit 0 and is dropped when the state becomes 2. A release flips bit 1 and is dropped when the state becomes 3. The sequence press, release, press, release therefore queues only the first press and the last release.
- R5: Command 0x01 empties the queue and then queues 0xFF, 0x04, 0x7F.
- R6: Commands 0x07 and 0x0F each empty the queue and then queue 0xFE, 0x00.
- R7: Command 0x0E queues nothing and causes the next accepted command byte to be discarded. Any command value not named in R5 to R7 has no effect.
- R8: The queue holds 256 bytes. A write to a full queue is dropped. A pop of an empty queue has no effect, and while the queue is empty `rx_data` reads 0x00.
- R9: Replies are written at most one byte per clock, starting the cycle after the command is accepted. A command strobed while a reply is still being written is ignored. A scancode write takes priority and delays the pending reply byte by one cycle. The queue is emptied in the same cycle as the first reply byte, which also removes scancodes queued before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_valid | input | 1 | Scancode strobe, one code per cycle |
| scan_code | input | 8 | Host-style scancode, bit 7 marks a release |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte sent to the keyboard |
| rx_pop | input | 1 | Removes the head byte of the queue |
| rx_data | output | 8 | Head byte of the queue, 0x00 when empty |
| rx_avail | output | 1 | Queue not empty |

## Verification
The hardest situation to reach is a collision between a scancode and a reply that is being sequenced. The two cases are a scancode landing in the cycle before the deferred queue clear and a scancode landing between two reply bytes. The bench drives the command strobe and then places a scancode strobe on a chosen following cycle. It then drains the queue to confirm that the first scancode was wiped by the clear and the second was interleaved. Filling the queue past 256 entries and popping it empty takes a long run of strobes, and the bench uses codes chosen to stay clear of the lock and prefix values.

// File: rtl/kbx_pkg.sv
package kbx_pkg;

  localparam logic [7:0] CODE_EXT_PFX = 8'hE0;
  localparam logic [7:0] CODE_CAPS_DN = 8'h3A;
  localparam logic [7:0] CODE_CAPS_UP = 8'hBA;
  localparam logic [7:0] CODE_NUM_DN  = 8'h45;
  localparam logic [7:0] CODE_NUM_UP  = 8'hC5;

  localparam logic [7:0] CMD_IDENT    = 8'h01;
  localparam logic [7:0] CMD_LAYOUT_A = 8'h07;
  localparam logic [7:0] CMD_LED      = 8'h0E;
  localparam logic [7:0] CMD_LAYOUT_B = 8'h0F;

  typedef enum logic [1:0] {
    RPL_IDLE   = 2'd0,
    RPL_IDENT  = 2'd1,
    RPL_LAYOUT = 2'd2
  } rpl_kind_e;

  function automatic logic [7:0] rpl_byte(rpl_kind_e kind, logic [1:0] idx);
    logic [7:0] b;
    b = 8'h00;
    case (kind)
      RPL_IDENT: begin
        case (idx)
          2'd0:    b = 8'hFF;
          2'd1:    b = 8'h04;
          default: b = 8'h7F;
        endcase
      end
      RPL_LAYOUT: b = (idx == 2'd0) ? 8'hFE : 8'h00;
      default:    b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [1:0] rpl_last(rpl_kind_e kind);
    return (kind == RPL_IDENT) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/kbx_keymap.sv
module kbx_keymap #(
  parameter int          IW      = 7,
  parameter logic [6:0]  KEY_XOR = 7'h2A
) (
  input  logic [IW-1:0] idx,
  output logic [IW-1:0] val
);
  localparam int ENTRIES = 2 ** IW;

  logic [IW-1:0] rom [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_rom
    assign rom[g] = IW'(g) ^ IW'(KEY_XOR);
  end

  assign val = rom[idx];
endmodule

// File: rtl/kbx_scan_front.sv
module kbx_scan_front
  import kbx_pkg::*;
#(
  parameter logic [6:0] NRM_XOR = 7'h2A,
  parameter logic [6:0] EXT_XOR = 7'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_valid,
  input  logic [7:0] scan_code,
  output logic       wr_req,
  output logic [7:0] wr_byte
);
  logic       ext_q, ext_d;
  logic [1:0] caps_q, caps_d;
  logic [1:0] num_q, num_d;
  logic       drop;
  logic [6:0] nrm_val, ext_val;

  kbx_keymap #(.IW(7), .KEY_XOR(NRM_XOR)) u_nrm (.idx(scan_code[6:0]), .val(nrm_val));
  kbx_keymap #(.IW(7), .KEY_XOR(EXT_XOR)) u_ext (.idx(scan_code[6:0]), .val(ext_val));

  always_comb begin
    ext_d  = ext_q;
    caps_d = caps_q;
    num_d  = num_q;
    drop   = 1'b0;
    wr_req = 1'b0;
    if (scan_valid) begin
      if (scan_code == CODE_EXT_PFX) begin
        ext_d = 1'b1;
      end else begin
        case (scan_code)
          CODE_CAPS_DN: begin
            caps_d = caps_q ^ 2'b01;
            drop   = (caps_d == 2'd2);
          end
          CODE_CAPS_UP: begin
            caps_d = caps_q ^ 2'b10;
            drop   = (caps_d == 2'd3);
          end
          CODE_NUM_DN: begin
            num_d = num_q ^ 2'b01;
            drop  = (num_d == 2'd2);
          end
          CODE_NUM_UP: begin
            num_d = num_q ^ 2'b10;
            drop  = (num_d == 2'd3);
          end
          default: drop = 1'b0;
        endcase
        if (!drop) begin
          wr_req = 1'b1;
          ext_d  = 1'b0;
        end
      end
    end
  end

  assign wr_byte = {scan_code[7], (ext_q ? ext_val : nrm_val)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= 1'b0;
      caps_q <= 2'd0;
      num_q  <= 2'd0;
    end else if (scan_valid) begin
      ext_q  <= ext_d;
      caps_q <= caps_d;
      num_q  <= num_d;
    end
  end
endmodule

// File: rtl/kbx_reply_seq.sv
module kbx_reply_seq
  import kbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       yield,
  output logic       wr_req,
  output logic       wr_clr,
  output logic [7:0] wr_byte
);
  rpl_kind_e  kind_q, kind_d;
  logic [1:0] idx_q, idx_d;
  logic       led_q, led_d;
  logic       busy;

  assign busy = (kind_q != RPL_IDLE);

  always_comb begin
    kind_d  = kind_q;
    idx_d   = idx_q;
    led_d   = led_q;
    wr_req  = 1'b0;
    wr_clr  = 1'b0;
    wr_byte = rpl_byte(kind_q, idx_q);
    if (!busy) begin
      if (cmd_valid) begin
        if (led_q) begin
          led_d = 1'b0;
        end else begin
          case (cmd_byte)
            CMD_IDENT: begin
              kind_d = RPL_IDENT;
              idx_d  = 2'd0;
            end
            CMD_LAYOUT_A, CMD_LAYOUT_B: begin
              kind_d = RPL_LAYOUT;
              idx_d  = 2'd0;
            end
            CMD_LED: led_d = 1'b1;
            default: led_d = 1'b0;
          endcase
        end
      end
    end else if (!yield) begin
      wr_req = 1'b1;
      wr_clr = (idx_q == 2'd0);
      if (idx_q == rpl_last(kind_q)) begin
        kind_d = RPL_IDLE;
        idx_d  = 2'd0;
      end else begin
        idx_d = idx_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= RPL_IDLE;
      idx_q  <= 2'd0;
      led_q  <= 1'b0;
    end else begin
      kind_q <= kind_d;
      idx_q  <= idx_d;
      led_q  <= led_d;
    end
  end
endmodule

// File: rtl/kbx_rx_fifo.sv
module kbx_rx_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       rd_en,
  output logic [DW-1:0]              rd_data,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d, waddr;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    waddr  = wptr_q;
    do_wr  = 1'b0;
    do_rd  = 1'b0;
    if (clr) begin
      waddr  = '0;
      do_wr  = wr_en;
      rptr_d = '0;
      wptr_d = wr_en ? AW'(1) : '0;
      cnt_d  = wr_en ? CW'(1) : '0;
    end else begin
      do_wr = wr_en && (cnt_q != CW'(DEPTH));
      do_rd = rd_en && (cnt_q != '0);
      if (do_wr) wptr_d = bump(wptr_q);
      if (do_rd) rptr_d = bump(rptr_q);
      cnt_d = cnt_q + CW'(do_wr) - CW'(do_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[waddr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rd_data = (cnt_q != '0) ? mem[rptr_q] : '0;
  assign level   = cnt_q;
endmodule

// File: rtl/kbd_xlate_top.sv
module kbd_xlate_top #(
  parameter int         DEPTH   = 256,
  parameter logic [6:0] NRM_XOR = 7'h2A,
  parameter logic [6:0] EXT_XOR = 7'h55
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_valid,
  input  logic [7:0] scan_code,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_byte,
  input  logic       rx_pop,
  output logic [7:0] rx_data,
  output logic       rx_avail
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic          scan_wr;
  logic [7:0]    scan_byte;
  logic          seq_wr, seq_clr;
  logic [7:0]    seq_byte;
  logic          fifo_wr;
  logic [7:0]    fifo_wdata;
  logic [CW-1:0] fifo_level;

  kbx_scan_front #(.NRM_XOR(NRM_XOR), .EXT_XOR(EXT_XOR)) u_front (
    .clk(clk), .rst_n(rst_n),
    .scan_valid(scan_valid), .scan_code(scan_code),
    .wr_req(scan_wr), .wr_byte(scan_byte)
  );

  kbx_reply_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .yield(scan_wr),
    .wr_req(seq_wr), .wr_clr(seq_clr), .wr_byte(seq_byte)
  );

  assign fifo_wr    = scan_wr | seq_wr;
  assign fifo_wdata = scan_wr ? scan_byte : seq_byte;

  kbx_rx_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .clr(seq_clr), .wr_en(fifo_wr), .wr_data(fifo_wdata),
    .rd_en(rx_pop), .rd_data(rx_data), .level(fifo_level)
  );

  assign rx_avail = (fifo_level != '0);
endmodule

// File: rtl/kbx_checker.sv
module kbx_checker #(
  parameter int DEPTH = 256,
  parameter int CW    = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_valid,
  input logic [7:0]    scan_code,
  input logic          rx_pop,
  input logic [7:0]    rx_data,
  input logic          scan_wr,
  input logic          fifo_wr,
  input logic [7:0]    fifo_wdata,
  input logic [CW-1:0] fifo_level
);
  p_empty_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_level == '0) |-> (rx_data == 8'h00));

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CW'(DEPTH));

  p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((fifo_level == '0) && rx_pop && !fifo_wr) |=> (fifo_level == '0));

  p_one_byte_per_clk_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, fifo_level} <= {1'b0, $past(fifo_level)} + 1));

  p_prefix_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_valid && scan_code == 8'hE0) |-> !scan_wr);

  p_release_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_wr |-> (fifo_wdata[7] == scan_code[7]));
endmodule

bind kbd_xlate_top kbx_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .scan_valid(scan_valid), .scan_code(scan_code),
  .rx_pop(rx_pop), .rx_data(rx_data),
  .scan_wr(scan_wr), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
  .fifo_level(fifo_level)
);

// File: tb/kbd_xlate_top_test.sv
module kbd_xlate_top_test;
  logic       clk;
  logic       rst_n;
  logic       scan_valid;
  logic [7:0] scan_code;
  logic       cmd_valid;
  logic [7:0] cmd_byte;
  logic       rx_pop;
  logic [7:0] rx_data;
  logic       rx_avail;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  kbd_xlate_top uut (
    .clk(clk), .rst_n(rst_n),
    .scan_valid(scan_valid), .scan_code(scan_code),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_avail(rx_avail)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] nmap(logic [7:0] c);
    return {c[7], c[6:0] ^ 7'h2A};
  endfunction

  function automatic logic [7:0] emap(logic [7:0] c);
    return {c[7], c[6:0] ^ 7'h55};
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_scan(logic [7:0] c);
    @(negedge clk);
    scan_valid = 1'b1;
    scan_code  = c;
    @(negedge clk);
    scan_valid = 1'b0;
  endtask

  task automatic send_cmd(logic [7:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_byte  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // pop one byte: sampled at a negedge, popped at the following posedge
  task automatic pop_expect(string tag, logic [7:0] exp);
    chk({tag, " avail"}, {8'h0, rx_avail}, 9'h1);
    chk({tag, " data"}, {1'b0, rx_data}, {1'b0, exp});
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
  endtask

  task automatic expect_empty(string tag);
    chk({tag, " empty avail"}, {8'h0, rx_avail}, 9'h0);
    chk({tag, " empty data"}, {1'b0, rx_data}, 9'h0);
  endtask

  task automatic drain();
    while (rx_avail) begin
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
    end
  endtask

  task automatic t_reset_r1();
    expect_empty("R1 reset");
  endtask

  task automatic t_plain_r2();
    send_scan(8'h1C);
    send_scan(8'h9C);
    send_scan(8'h00);
    send_scan(8'hFF);
    pop_expect("R2 press", nmap(8'h1C));
    pop_expect("R2 release", nmap(8'h9C));
    pop_expect("R2 zero", nmap(8'h00));
    pop_expect("R2 all ones", nmap(8'hFF));
    expect_empty("R2 after");
  endtask

  task automatic t_prefix_r3();
    send_scan(8'hE0);
    expect_empty("R3 prefix silent");
    send_scan(8'h48);
    send_scan(8'h48);
    send_scan(8'hE0);
    send_scan(8'hC8);
    pop_expect("R3 extended", emap(8'h48));
    pop_expect("R3 flag cleared", nmap(8'h48));
    pop_expect("R3 extended release", emap(8'hC8));
    expect_empty("R3 after");
  endtask

  task automatic t_lock_r4();
    send_scan(8'h3A);
    send_scan(8'hBA);
    send_scan(8'h3A);
    pop_expect("R4 caps first press", nmap(8'h3A));
    expect_empty("R4 caps drops");
    send_scan(8'hBA);
    pop_expect("R4 caps last release", nmap(8'hBA));
    expect_empty("R4 caps after");
    send_scan(8'h45);
    send_scan(8'hC5);
    send_scan(8'h45);
    send_scan(8'hC5);
    pop_expect("R4 num first press", nmap(8'h45));
    pop_expect("R4 num last release", nmap(8'hC5));
    expect_empty("R4 num after");
  endtask

  task automatic t_ident_r5();
    send_scan(8'h11);
    send_cmd(8'h01);
    idle(5);
    pop_expect("R5 byte0", 8'hFF);
    pop_expect("R5 byte1", 8'h04);
    pop_expect("R5 byte2", 8'h7F);
    expect_empty("R5 cleared");
  endtask

  task automatic t_layout_r6();
    send_scan(8'h12);
    send_cmd(8'h07);
    idle(4);
    pop_expect("R6 07 byte0", 8'hFE);
    pop_expect("R6 07 byte1", 8'h00);
    expect_empty("R6 07 after");
    send_cmd(8'h0F);
    idle(4);
    pop_expect("R6 0F byte0", 8'hFE);
    pop_expect("R6 0F byte1", 8'h00);
    expect_empty("R6 0F after");
  endtask

  task automatic t_led_r7();
    send_scan(8'h21);
    send_cmd(8'h0E);
    idle(3);
    send_cmd(8'h01);
    idle(5);
    send_cmd(8'h55);
    idle(3);
    pop_expect("R7 queue untouched", nmap(8'h21));
    expect_empty("R7 swallowed");
    send_cmd(8'h01);
    idle(5);
    pop_expect("R7 flag cleared", 8'hFF);
    drain();
  endtask

  task automatic t_collide_r9();
    // command strobed while busy is ignored
    send_cmd(8'h01);
    cmd_valid = 1'b1;
    cmd_byte  = 8'h07;
    @(negedge clk);
    cmd_valid = 1'b0;
    idle(4);
    pop_expect("R9 busy b0", 8'hFF);
    pop_expect("R9 busy b1", 8'h04);
    pop_expect("R9 busy b2", 8'h7F);
    expect_empty("R9 busy after");
    // scancode in the cycle before the deferred clear is wiped
    send_cmd(8'h01);
    scan_valid = 1'b1;
    scan_code  = 8'h33;
    @(negedge clk);
    scan_valid = 1'b0;
    idle(4);
    pop_expect("R9 wiped b0", 8'hFF);
    pop_expect("R9 wiped b1", 8'h04);
    pop_expect("R9 wiped b2", 8'h7F);
    expect_empty("R9 wiped after");
    // scancode between reply bytes is interleaved
    send_cmd(8'h07);
    @(negedge clk);
    scan_valid = 1'b1;
    scan_code  = 8'h34;
    @(negedge clk);
    scan_valid = 1'b0;
    idle(3);
    pop_expect("R9 mix b0", 8'hFE);
    pop_expect("R9 mix scan", nmap(8'h34));
    pop_expect("R9 mix b1", 8'h00);
    expect_empty("R9 mix after");
  endtask

  task automatic t_full_r8();
    for (int i = 0; i < 260; i++) send_scan(8'((i % 50) + 1));
    for (int i = 0; i < 256; i++) pop_expect("R8 fill order", nmap(8'((i % 50) + 1)));
    expect_empty("R8 drop when full");
    rx_pop = 1'b1;
    @(negedge clk);
    rx_pop = 1'b0;
    expect_empty("R8 pop empty");
    send_scan(8'h05);
    pop_expect("R8 after empty pop", nmap(8'h05));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    scan_valid = 1'b0;
    scan_code  = 8'h00;
    cmd_valid  = 1'b0;
    cmd_byte   = 8'h00;
    rx_pop     = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset_r1();
    t_plain_r2();
    t_prefix_r3();
    t_lock_r4();
    t_ident_r5();
    t_layout_r6();
    t_led_r7();
    t_collide_r9();
    t_full_r8();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule